// File: doc/BRIEF.md
# Dual Compare Timer System Controller

This block is a word-addressed system controller register file with two identical up-counting compare timers. Each timer holds a control word (an enable bit and an auto-restart bit), a compare value and a counter. While enabled, the counter advances by one every clock until it equals the compare value. The timer then emits a single-cycle interrupt pulse. After the pulse it either wraps to zero and keeps running, or stops with its enable bit cleared.

Around the timers sit a few plain registers: a GPIO output word that also drives pins, a GPIO interrupt-enable word and a scratchpad. A write-lock flag becomes 1 on any write and stays set until reset. A command port turns one specific code into a shutdown-request pulse and always reads back a ready flag. Read-only words give a GPIO strapping value, the clock frequency, a capability word and a system identifier. A write to the identifier word raises a reset-request pulse. Reads have no side effects and return data in the same cycle, selected by the address.

Each timer runs a two-state machine. The states are HALT and RUN. HALT goes to RUN when the control word is written with the enable bit set. RUN goes to HALT in two cases: the control word is written with the enable bit clear, or a compare match occurs with auto-restart clear. The lock flag runs a two-state machine with states OPEN and LOCKED. OPEN goes to LOCKED on any write to the lock word, and LOCKED has no exit except reset.

Top module: `sysctl_dual_timer`

## Requirements
- R1: After reset, reads return the following, and all request and interrupt outputs and `gpio_out` are 0:
  - word 0 (GPIO in) returns 0x00000001;
  - word 16 (command port) returns 0x00000001;
  - word 29 returns 80000000;
  - word 30 returns 0;
  - word 31 returns 0x10014D31;
  - every other mapped word returns 0.
- R2: The following words read back the last value written:
  - word 1 (GPIO out, which also drives `gpio_out`);
  - word 2 (GPIO interrupt enable);
  - word 20 (scratchpad);
  - the timer compare words 5 and 9;
  - the timer counter words 6 and 10.
  The timer control words 4 and 8 keep only bit 0 (enable) and bit 1 (auto-restart); their other bits read 0.
- R3: In a cycle with no write to its three words, an enabled timer whose counter differs from its compare value advances the counter by one. A halted timer holds its counter. A cycle that writes any of a timer's words applies the write and does not count.
- R4: The matching cycle is a cycle in which an enabled timer sees counter equal to compare and receives no write to its words. The timer's `timer_irq` bit is high for exactly the cycle after each matching cycle.
- R5: With auto-restart clear, the match stops the timer. The enable bit reads 0 from the cycle the interrupt is high, and the counter holds the compare value.
- R6: With auto-restart set, the counter reads 0 in the cycle the interrupt is high. The enable bit stays 1 and counting continues from 0.
- R7: Writes to words 0, 29 and 30 and to unmapped words change nothing. Unmapped words read 0.
- R8: Any write to word 21 makes it read 1, and it stays 1 until reset.
- R9: A write to word 16 whose bits 15:0 equal 0x000E makes `shutdown_req` high for exactly the next cycle. Any other value produces no pulse. Word 16 always reads 1.
- R10: Any write to word 31 makes `reset_req` high for exactly the next cycle, and the identifier still reads 0x10014D31.
- R11: The two timers are independent. Timer 0 drives `timer_irq[0]`, timer 1 drives `timer_irq[1]`, and activity on one never disturbs the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 5 | Word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| gpio_out | output | 32 | GPIO output word |
| timer_irq | output | 2 | One-cycle interrupt pulse per timer |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reset_req | output | 1 | One-cycle reset request |

## Verification
The hardest case to reach from the ports is the exact cycle of a compare match relative to the enabling write, in both stop and wrap modes. Off-by-one slips hide there, and the compare-equals-zero case makes the interrupt fire on every cycle. The bench covers this with a sweep over both timers, both auto-restart settings, every compare value from 0 to 5 and every starting count up to it. For each run it predicts the pulse cycle as compare minus start plus one, then reads the counter and control word in that same cycle.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

    localparam int unsigned SCTL_AW    = 5;
    localparam int unsigned NUM_TIMERS = 2;

    // word addresses
    localparam logic [SCTL_AW-1:0] A_GPIO_IN  = 5'd0;
    localparam logic [SCTL_AW-1:0] A_GPIO_OUT = 5'd1;
    localparam logic [SCTL_AW-1:0] A_GPIO_IEN = 5'd2;
    localparam logic [SCTL_AW-1:0] A_CMD      = 5'd16;
    localparam logic [SCTL_AW-1:0] A_SCRATCH  = 5'd20;
    localparam logic [SCTL_AW-1:0] A_LOCK     = 5'd21;
    localparam logic [SCTL_AW-1:0] A_CLKFREQ  = 5'd29;
    localparam logic [SCTL_AW-1:0] A_CAPS     = 5'd30;
    localparam logic [SCTL_AW-1:0] A_SYSID    = 5'd31;

    // timer block layout: base + stride * index + offset
    localparam int unsigned TMR_BASE   = 4;
    localparam int unsigned TMR_STRIDE = 4;
    localparam int unsigned OFS_CTRL   = 0;
    localparam int unsigned OFS_CMP    = 1;
    localparam int unsigned OFS_CNT    = 2;

    localparam int unsigned CTL_EN   = 0;
    localparam int unsigned CTL_AUTO = 1;

    localparam logic [15:0] SHUTDOWN_CODE = 16'h000E;

    typedef enum logic {T_HALT, T_RUN} tmr_state_e;
    typedef enum logic {L_OPEN, L_LOCKED} lock_state_e;

    function automatic logic [SCTL_AW-1:0] tmr_addr(input int unsigned idx, input int unsigned ofs);
        return SCTL_AW'(TMR_BASE + idx * TMR_STRIDE + ofs);
    endfunction

endpackage

// File: rtl/sctl_timer.sv
module sctl_timer
    import sctl_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_ctrl,
    input  logic         wr_cmp,
    input  logic         wr_cnt,
    input  logic [W-1:0] wdata,
    output logic [1:0]   ctrl_o,
    output logic [W-1:0] cmp_o,
    output logic [W-1:0] cnt_o,
    output logic         irq_o
);

    tmr_state_e   state_q, state_d;
    logic         auto_q;
    logic [W-1:0] cmp_q, cnt_q;
    logic         irq_q;
    logic         any_wr;
    logic         match;

    assign any_wr = wr_ctrl | wr_cmp | wr_cnt;
    assign match  = (cnt_q == cmp_q);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            T_HALT: begin
                if (wr_ctrl && wdata[CTL_EN]) state_d = T_RUN;
            end
            T_RUN: begin
                if (wr_ctrl && !wdata[CTL_EN])      state_d = T_HALT;
                else if (!any_wr && match && !auto_q) state_d = T_HALT;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= T_HALT;
        else        state_q <= state_d;
    end

    // data and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            auto_q <= 1'b0;
            cmp_q  <= '0;
            cnt_q  <= '0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (wr_ctrl) auto_q <= wdata[CTL_AUTO];
            if (wr_cmp)  cmp_q  <= wdata;
            if (wr_cnt)  cnt_q  <= wdata;
            if (!any_wr && state_q == T_RUN) begin
                if (match) begin
                    irq_q <= 1'b1;
                    if (auto_q) cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign ctrl_o = {auto_q, state_q == T_RUN};
    assign cmp_o  = cmp_q;
    assign cnt_o  = cnt_q;
    assign irq_o  = irq_q;

endmodule

// File: rtl/sctl_misc_regs.sv
module sctl_misc_regs
    import sctl_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SCTL_AW-1:0] wr_addr,
    input  logic [DW-1:0]      wr_data,
    output logic [DW-1:0]      gpio_out_q,
    output logic [DW-1:0]      gpio_ien_q,
    output logic [DW-1:0]      scratch_q,
    output logic               locked_o,
    output logic               shutdown_o,
    output logic               reset_o
);

    lock_state_e lock_q, lock_d;

    always_comb begin
        lock_d = lock_q;
        unique case (lock_q)
            L_OPEN:   if (wr_en && wr_addr == A_LOCK) lock_d = L_LOCKED;
            L_LOCKED: lock_d = L_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_q <= L_OPEN;
        else        lock_q <= lock_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gpio_out_q <= '0;
            gpio_ien_q <= '0;
            scratch_q  <= '0;
            shutdown_o <= 1'b0;
            reset_o    <= 1'b0;
        end else begin
            shutdown_o <= wr_en && (wr_addr == A_CMD) && (wr_data[15:0] == SHUTDOWN_CODE);
            reset_o    <= wr_en && (wr_addr == A_SYSID);
            if (wr_en && wr_addr == A_GPIO_OUT) gpio_out_q <= wr_data;
            if (wr_en && wr_addr == A_GPIO_IEN) gpio_ien_q <= wr_data;
            if (wr_en && wr_addr == A_SCRATCH)  scratch_q  <= wr_data;
        end
    end

    assign locked_o = (lock_q == L_LOCKED);

endmodule

// File: rtl/sysctl_dual_timer.sv
module sysctl_dual_timer
    import sctl_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter logic [31:0] SYS_ID    = 32'h10014D31,
    parameter logic [31:0] CLK_HZ    = 32'd80000000,
    parameter logic [31:0] CAPS      = 32'h0,
    parameter logic [31:0] STRAPPING = 32'h1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [SCTL_AW-1:0]    bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic [DATA_W-1:0]     gpio_out,
    output logic [NUM_TIMERS-1:0] timer_irq,
    output logic                  shutdown_req,
    output logic                  reset_req
);

    logic [NUM_TIMERS-1:0][1:0]        t_ctrl;
    logic [NUM_TIMERS-1:0][DATA_W-1:0] t_cmp;
    logic [NUM_TIMERS-1:0][DATA_W-1:0] t_cnt;
    logic [DATA_W-1:0] gpio_ien;
    logic [DATA_W-1:0] scratch;
    logic              lock_flag;

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
        sctl_timer #(.W(DATA_W)) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_ctrl (bus_wr && bus_addr == tmr_addr(i, OFS_CTRL)),
            .wr_cmp  (bus_wr && bus_addr == tmr_addr(i, OFS_CMP)),
            .wr_cnt  (bus_wr && bus_addr == tmr_addr(i, OFS_CNT)),
            .wdata   (bus_wdata),
            .ctrl_o  (t_ctrl[i]),
            .cmp_o   (t_cmp[i]),
            .cnt_o   (t_cnt[i]),
            .irq_o   (timer_irq[i])
        );
    end

    sctl_misc_regs #(.DW(DATA_W)) u_misc (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_wr),
        .wr_addr    (bus_addr),
        .wr_data    (bus_wdata),
        .gpio_out_q (gpio_out),
        .gpio_ien_q (gpio_ien),
        .scratch_q  (scratch),
        .locked_o   (lock_flag),
        .shutdown_o (shutdown_req),
        .reset_o    (reset_req)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_GPIO_IN:  bus_rdata = DATA_W'(STRAPPING);
            A_GPIO_OUT: bus_rdata = gpio_out;
            A_GPIO_IEN: bus_rdata = gpio_ien;
            A_CMD:      bus_rdata = DATA_W'(1);
            A_SCRATCH:  bus_rdata = scratch;
            A_LOCK:     bus_rdata = DATA_W'(lock_flag);
            A_CLKFREQ:  bus_rdata = DATA_W'(CLK_HZ);
            A_CAPS:     bus_rdata = DATA_W'(CAPS);
            A_SYSID:    bus_rdata = DATA_W'(SYS_ID);
            default: begin
                for (int i = 0; i < NUM_TIMERS; i++) begin
                    if (bus_addr == tmr_addr(i, OFS_CTRL)) bus_rdata = DATA_W'(t_ctrl[i]);
                    if (bus_addr == tmr_addr(i, OFS_CMP))  bus_rdata = t_cmp[i];
                    if (bus_addr == tmr_addr(i, OFS_CNT))  bus_rdata = t_cnt[i];
                end
            end
        endcase
    end

endmodule

// File: rtl/sctl_checker.sv
module sctl_checker
    import sctl_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned NT = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic [SCTL_AW-1:0]  bus_addr,
    input logic [DW-1:0]       bus_wdata,
    input logic [NT-1:0]       timer_irq,
    input logic                shutdown_req,
    input logic                reset_req,
    input logic                lock_flag,
    input logic [NT-1:0][1:0]  t_ctrl,
    input logic [NT-1:0][DW-1:0] t_cmp,
    input logic [NT-1:0][DW-1:0] t_cnt
);

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_flag |=> lock_flag); // R8

    AST_SHUTDOWN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> $past(bus_wr && bus_addr == A_CMD && bus_wdata[15:0] == SHUTDOWN_CODE)); // R9

    AST_RESET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(bus_wr && bus_addr == A_SYSID)); // R10

    for (genvar i = 0; i < NT; i++) begin : g_chk
        logic wr_t;
        assign wr_t = bus_wr && (bus_addr == tmr_addr(i, OFS_CTRL) ||
                                 bus_addr == tmr_addr(i, OFS_CMP)  ||
                                 bus_addr == tmr_addr(i, OFS_CNT));

        AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!t_ctrl[i][CTL_EN] && !wr_t) |=> $stable(t_cnt[i])); // R3

        AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (t_ctrl[i][CTL_EN] && !wr_t && t_cnt[i] != t_cmp[i]) |=> t_cnt[i] == DW'($past(t_cnt[i]) + 1'b1)); // R3

        AST_IRQ_AT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            timer_irq[i] |-> $past(t_ctrl[i][CTL_EN] && !wr_t && t_cnt[i] == t_cmp[i])); // R4

        AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
            (timer_irq[i] && !$past(t_ctrl[i][CTL_AUTO])) |-> (!t_ctrl[i][CTL_EN] && t_cnt[i] == $past(t_cnt[i]))); // R5

        AST_AUTO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            (timer_irq[i] && $past(t_ctrl[i][CTL_AUTO])) |-> (t_cnt[i] == '0 && t_ctrl[i][CTL_EN])); // R6
    end

endmodule

bind sysctl_dual_timer sctl_checker #(.DW(DATA_W), .NT(NUM_TIMERS)) u_sctl_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .timer_irq    (timer_irq),
    .shutdown_req (shutdown_req),
    .reset_req    (reset_req),
    .lock_flag    (lock_flag),
    .t_ctrl       (t_ctrl),
    .t_cmp        (t_cmp),
    .t_cnt        (t_cnt)
);

// File: tb/sysctl_dual_timer_tb_top.sv
module sysctl_dual_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] gpio_out;
    logic [1:0]  timer_irq;
    logic        shutdown_req;
    logic        reset_req;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    sysctl_dual_timer dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .gpio_out     (gpio_out),
        .timer_irq    (timer_irq),
        .shutdown_req (shutdown_req),
        .reset_req    (reset_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [4:0] taddr(input int t, input int ofs);
        return 5'(4 + 4 * t + ofs);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(5'd0, r);  check("R1 gpio_in", r, 32'h1);
        bus_read(5'd16, r); check("R1 cmd ready", r, 32'h1);
        bus_read(5'd29, r); check("R1 clkfreq", r, 32'd80000000);
        bus_read(5'd30, r); check("R1 caps", r, 32'h0);
        bus_read(5'd31, r); check("R1 sysid", r, 32'h10014D31);
        for (int a = 1; a < 29; a++) begin
            if (a != 16) begin
                bus_read(5'(a), r); check($sformatf("R1 word %0d", a), r, 32'h0);
            end
        end
        check("R1 outputs", {28'h0, timer_irq, shutdown_req, reset_req}, 32'h0);
        check("R1 gpio_out", gpio_out, 32'h0);

        // R2 writable readback
        bus_write(5'd1, 32'hA5A50F0F);
        bus_read(5'd1, r); check("R2 gpio out", r, 32'hA5A50F0F);
        check("R2 gpio pin", gpio_out, 32'hA5A50F0F);
        bus_write(5'd2, 32'h12345678);
        bus_read(5'd2, r); check("R2 gpio ien", r, 32'h12345678);
        bus_write(5'd20, 32'hDEADBEEF);
        bus_read(5'd20, r); check("R2 scratch", r, 32'hDEADBEEF);
        for (int t = 0; t < 2; t++) begin
            bus_write(taddr(t, 1), 32'h0000_1000 + 32'(t));
            bus_read(taddr(t, 1), r); check("R2 cmp", r, 32'h0000_1000 + 32'(t));
            bus_write(taddr(t, 2), 32'h0000_0200 + 32'(t));
            bus_read(taddr(t, 2), r); check("R2 cnt", r, 32'h0000_0200 + 32'(t));
            bus_write(taddr(t, 0), 32'hFFFF_FFFE);
            bus_read(taddr(t, 0), r); check("R2 ctrl mask", r, 32'h2);
            bus_write(taddr(t, 0), 32'h0);
        end

        // R7 read-only and unmapped
        bus_write(5'd0, 32'hFFFF_FFFF);  bus_read(5'd0, r);  check("R7 gpio_in", r, 32'h1);
        bus_write(5'd29, 32'h0);         bus_read(5'd29, r); check("R7 clkfreq", r, 32'd80000000);
        bus_write(5'd30, 32'hFFFF_FFFF); bus_read(5'd30, r); check("R7 caps", r, 32'h0);
        bus_write(5'd3, 32'hFFFF_FFFF);  bus_read(5'd3, r);  check("R7 unmapped", r, 32'h0);

        // R8 lock
        bus_read(5'd21, r); check("R8 lock open", r, 32'h0);
        bus_write(5'd21, 32'h0); bus_read(5'd21, r); check("R8 lock set", r, 32'h1);
        bus_write(5'd21, 32'h0); bus_read(5'd21, r); check("R8 lock sticky", r, 32'h1);

        // R9 shutdown
        bus_write(5'd16, 32'h1234_000E);
        check("R9 shutdown pulse", {31'h0, shutdown_req}, 32'h1);
        @(negedge clk);
        check("R9 shutdown single", {31'h0, shutdown_req}, 32'h0);
        bus_write(5'd16, 32'h0001_000F);
        check("R9 other code", {31'h0, shutdown_req}, 32'h0);
        bus_read(5'd16, r); check("R9 ready", r, 32'h1);

        // R10 reset request
        bus_write(5'd31, 32'h0);
        check("R10 reset pulse", {31'h0, reset_req}, 32'h1);
        @(negedge clk);
        check("R10 reset single", {31'h0, reset_req}, 32'h0);
        bus_read(5'd31, r); check("R10 sysid kept", r, 32'h10014D31);

        // R3 counting and halt
        bus_write(taddr(1, 1), 32'd100);
        bus_write(taddr(1, 2), 32'd0);
        bus_write(taddr(1, 0), 32'h1);
        repeat (5) @(negedge clk);
        bus_read(taddr(1, 2), r); check("R3 count", r, 32'd5);
        bus_write(taddr(1, 0), 32'h0);
        repeat (3) @(negedge clk);
        bus_read(taddr(1, 2), r); check("R3 halt hold", r, 32'd6);

        // R4 R5 R6 R11 sweep
        for (int t = 0; t < 2; t++) begin
            for (int au = 0; au < 2; au++) begin
                for (int cmp = 0; cmp < 6; cmp++) begin
                    for (int c0 = 0; c0 <= cmp; c0++) begin
                        int n;
                        bus_write(taddr(t, 0), 32'h0);
                        bus_write(taddr(t, 1), 32'(cmp));
                        bus_write(taddr(t, 2), 32'(c0));
                        bus_write(taddr(t, 0), 32'(1 + 2 * au));
                        n = 0;
                        while (n < 40) begin
                            @(negedge clk); #1;
                            n++;
                            if (timer_irq[t]) break;
                        end
                        check("R4 irq cycle", 32'(n), 32'(cmp - c0 + 1));
                        check("R11 other quiet", {31'h0, timer_irq[1 - t]}, 32'h0);
                        if (au == 0) begin
                            bus_read(taddr(t, 2), r); check("R5 cnt held", r, 32'(cmp));
                            bus_read(taddr(t, 0), r); check("R5 enable cleared", r, 32'h0);
                        end else begin
                            bus_read(taddr(t, 2), r); check("R6 wrap zero", r, 32'h0);
                            bus_read(taddr(t, 0), r); check("R6 still enabled", r, 32'h3);
                        end
                        @(negedge clk); #1;
                        if (cmp > 0)
                            check("R4 single pulse", {31'h0, timer_irq[t]}, 32'h0);
                        if (au == 1 && cmp > 0) begin
                            bus_read(taddr(t, 2), r); check("R6 continues", r, 32'h1);
                        end
                    end
                end
            end
            bus_write(taddr(t, 0), 32'h0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule